// File: doc/BRIEF.md
# Seconds-Count Real-Time Clock

This block keeps a free-running seconds count for a chip. A slow enable at the crystal rate, nominally 32.768 kHz, is divided down to one pulse per second, and each pulse advances the count. A second register holds an alarm time. When the count reaches that time, the block raises a single-clock interrupt pulse. If enabled, the same pulse can also wake the power manager. A narrow register port lets software read the count, load a new time, program the alarm and set the control and charger-selection fields.

The control and charger registers use a masked write. Bits 31:16 of the write data choose which bits of bits 15:0 take effect, so one software write can change a single bit without a read first. The count and the alarm are always cleared by power-on reset. A separate system reset also clears them, unless software has set the keep bit. The counter can also be frozen.

Top module: `secs_rtc`

## Requirements
- R1: After power-on reset (`por_n` low) the count, the alarm, the control and the charger fields are zero. Every register offset reads 0 and `irq_o` and `pm_wake_o` are low.
- R2: The count advances by exactly one on every PRESCALE-th clock in which `tick_en` is high. Clocks with `tick_en` low do not advance the divider.
- R3: A write to offset 0x4C loads the count with the write data and restarts the divider phase. The next increment therefore needs PRESCALE more `tick_en` pulses. A read of offset 0x44 returns the count, and a read of 0x4C returns 0. Read data appears on `bus_rdata` one clock after the read strobe.
- R4: The count wraps from 0xFFFFFFFF to 0 on the next second.
- R5: The control register is at offset 0x40. A write changes control bit n only when write bit n+16 is set. Reads return bits 5:0 with bits 31:6 zero. The control bits are: 0 alarm enable, 1 route the alarm to `pm_wake_o`, 2 overdue alarm, 3 hold the divider at phase zero, 4 keep the count and alarm through system reset, 5 freeze the count.
- R6: The charger register is at offset 0x5C and uses the same masked write. Bits 3:2 are the resistor code on `chg_rsel_o`, bit 1 is diode off on `chg_diode_off_o`, and bit 0 is charge enable on `chg_en_o`. Reads return bits 3:0 with the upper bits zero.
- R7: With alarm enable set and a nonzero alarm (offset 0x50), the clock after the count becomes equal to the alarm makes `irq_o` high for exactly one clock. A match gives one pulse only.
- R8: An alarm value of zero never raises `irq_o`, even when the count is zero.
- R9: With overdue set, writing an alarm value below the current count raises one pulse. With overdue clear, such a write raises none.
- R10: `pm_wake_o` pulses together with `irq_o` when control bit 1 is set, and stays low when it is clear.
- R11: While freeze is set, seconds do not change the count. Time loads and reads still work, and counting resumes when freeze is cleared.
- R12: A system reset (`sys_rst_n` low at a clock edge) with keep clear zeroes the count, the alarm and the divider. With keep set it leaves them untouched. It never changes the control or charger fields.
- R13: While the divider hold bit is set, no seconds are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst_n | input | 1 | Synchronous system reset, active low, subject to keep bit |
| tick_en | input | 1 | One-clock enable at the crystal rate |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Alarm interrupt, one-clock pulse |
| pm_wake_o | output | 1 | Alarm pulse routed to power management |
| chg_rsel_o | output | 2 | Charger resistor code |
| chg_diode_off_o | output | 1 | Charger diode bypass |
| chg_en_o | output | 1 | Charger enable |

## Verification
The bench builds the block with PRESCALE set to 4 and keeps CNT_W, DATA_W and ADDR_W at their defaults. With that divider, a second costs four enable pulses. Alarm matches, freeze, divider hold and divider restart after a time load can therefore all be observed to the exact pulse within a few dozen clocks. The wrap from the maximum count is reached by loading 0xFFFFFFFF instead of waiting for it. The full 32-bit width is kept, so the zero-alarm check at the wrap runs on the real boundary.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int OFF_CTRL  = 'h40;
   localparam int OFF_COUNT = 'h44;
   localparam int OFF_TSET  = 'h4C;
   localparam int OFF_ALARM = 'h50;
   localparam int OFF_CHG   = 'h5C;

   localparam int CTRL_W  = 6;
   localparam int CHG_W   = 4;
   localparam int MASK_LO = 16;

   // bit 5 down to bit 0
   typedef struct packed {
      logic freeze;
      logic keep;
      logic ps_hold;
      logic overdue;
      logic pm_route;
      logic alm_en;
   } ctrl_t;

   // bit 3 down to bit 0
   typedef struct packed {
      logic [1:0] rsel;
      logic       diode_off;
      logic       en;
   } chg_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int PRESCALE = 32768
) (
   input  logic clk,
   input  logic por_n,
   input  logic clr,
   input  logic tick_en,
   output logic sec_pulse
);
   generate
      if (PRESCALE == 1) begin : g_direct
         assign sec_pulse = tick_en & ~clr;
      end else begin : g_count
         localparam int PS_W = $clog2(PRESCALE);
         localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);
         logic [PS_W-1:0] phase_q;

         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               phase_q <= '0;
            end else if (clr) begin
               phase_q <= '0;
            end else if (tick_en) begin
               phase_q <= (phase_q == LAST) ? '0 : phase_q + PS_W'(1);
            end
         end

         assign sec_pulse = tick_en & ~clr & (phase_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             soft_clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic [CNT_W-1:0] count
);
   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         count_q <= '0;
      end else if (soft_clr) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= load_val;
      end else if (step) begin
         count_q <= count_q + CNT_W'(1);   // wraps at the top
      end
   end

   assign count = count_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             soft_clr,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] alarm,
   input  logic             alm_en,
   input  logic             overdue_en,
   input  logic             pm_route,
   output logic             irq,
   output logic             pm_wake
);
   logic hit, hit_q, irq_q, pm_q, rise;

   // level condition; the pulse comes from its rising edge
   assign hit  = alm_en && (alarm != '0) &&
                 ((count == alarm) || (overdue_en && (alarm < count)));
   assign rise = hit & ~hit_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         hit_q <= 1'b0;
         irq_q <= 1'b0;
         pm_q  <= 1'b0;
      end else if (soft_clr) begin
         hit_q <= 1'b0;
         irq_q <= 1'b0;
         pm_q  <= 1'b0;
      end else begin
         hit_q <= hit;
         irq_q <= rise;
         pm_q  <= rise & pm_route;
      end
   end

   assign irq     = irq_q;
   assign pm_wake = pm_q;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
   import rtc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              soft_clr,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  count,
   output logic [DATA_W-1:0] bus_rdata,
   output ctrl_t             ctrl,
   output chg_t              chg,
   output logic [CNT_W-1:0]  alarm,
   output logic              time_load,
   output logic [CNT_W-1:0]  time_val
);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);
   localparam logic [ADDR_W-1:0] A_TSET  = ADDR_W'(OFF_TSET);
   localparam logic [ADDR_W-1:0] A_ALARM = ADDR_W'(OFF_ALARM);
   localparam logic [ADDR_W-1:0] A_CHG   = ADDR_W'(OFF_CHG);

   logic wr, rd;
   logic wr_ctrl, wr_chg, wr_alarm;
   logic [CTRL_W-1:0] ctrl_bits;
   logic [CHG_W-1:0]  chg_bits;
   logic [CNT_W-1:0]  alarm_q;
   logic [DATA_W-1:0] rdata_q;

   assign wr       = bus_sel & bus_we;
   assign rd       = bus_sel & ~bus_we;
   assign wr_ctrl  = wr && (bus_addr == A_CTRL);
   assign wr_chg   = wr && (bus_addr == A_CHG);
   assign wr_alarm = wr && (bus_addr == A_ALARM);

   assign time_load = wr && (bus_addr == A_TSET);
   assign time_val  = bus_wdata[CNT_W-1:0];

   // per-bit masked write: enable for bit i sits at bit i+16
   genvar gi;
   generate
      for (gi = 0; gi < CTRL_W; gi++) begin : g_ctrl_bit
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               ctrl_bits[gi] <= 1'b0;
            end else if (wr_ctrl && bus_wdata[MASK_LO + gi]) begin
               ctrl_bits[gi] <= bus_wdata[gi];
            end
         end
      end
      for (gi = 0; gi < CHG_W; gi++) begin : g_chg_bit
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               chg_bits[gi] <= 1'b0;
            end else if (wr_chg && bus_wdata[MASK_LO + gi]) begin
               chg_bits[gi] <= bus_wdata[gi];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         alarm_q <= '0;
      end else if (soft_clr) begin
         alarm_q <= '0;
      end else if (wr_alarm) begin
         alarm_q <= bus_wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         rdata_q <= '0;
      end else if (rd) begin
         case (bus_addr)
            A_CTRL:  rdata_q <= DATA_W'(ctrl_bits);
            A_COUNT: rdata_q <= DATA_W'(count);
            A_ALARM: rdata_q <= DATA_W'(alarm_q);
            A_CHG:   rdata_q <= DATA_W'(chg_bits);
            default: rdata_q <= '0;
         endcase
      end
   end

   assign ctrl      = ctrl_t'(ctrl_bits);
   assign chg       = chg_t'(chg_bits);
   assign alarm     = alarm_q;
   assign bus_rdata = rdata_q;
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
   import rtc_pkg::*;
#(
   parameter int PRESCALE = 32768,
   parameter int CNT_W    = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              tick_en,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              pm_wake_o,
   output logic [1:0]        chg_rsel_o,
   output logic              chg_diode_off_o,
   output logic              chg_en_o
);
   generate
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("PRESCALE must be at least 1");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie in 2..DATA_W");
      end
      if (DATA_W < MASK_LO + CTRL_W) begin : g_bad_data
         $error("DATA_W too narrow for masked writes");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ADDR_W must reach offset 0x5C");
      end
   endgenerate

   ctrl_t            ctrl_q;
   chg_t             chg_q;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] alarm_q;
   logic [CNT_W-1:0] time_val;
   logic             time_load;
   logic             soft_clr;
   logic             ps_clr;
   logic             sec_pulse;

   assign soft_clr = ~sys_rst_n & ~ctrl_q.keep;
   assign ps_clr   = soft_clr | ctrl_q.ps_hold | time_load;

   rtc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .por_n     (por_n),
      .soft_clr  (soft_clr),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .count     (count_q),
      .bus_rdata (bus_rdata),
      .ctrl      (ctrl_q),
      .chg       (chg_q),
      .alarm     (alarm_q),
      .time_load (time_load),
      .time_val  (time_val)
   );

   rtc_prescaler #(.PRESCALE(PRESCALE)) u_ps (
      .clk       (clk),
      .por_n     (por_n),
      .clr       (ps_clr),
      .tick_en   (tick_en),
      .sec_pulse (sec_pulse)
   );

   rtc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .por_n    (por_n),
      .soft_clr (soft_clr),
      .load     (time_load),
      .load_val (time_val),
      .step     (sec_pulse & ~ctrl_q.freeze),
      .count    (count_q)
   );

   rtc_alarm #(.CNT_W(CNT_W)) u_alm (
      .clk        (clk),
      .por_n      (por_n),
      .soft_clr   (soft_clr),
      .count      (count_q),
      .alarm      (alarm_q),
      .alm_en     (ctrl_q.alm_en),
      .overdue_en (ctrl_q.overdue),
      .pm_route   (ctrl_q.pm_route),
      .irq        (irq_o),
      .pm_wake    (pm_wake_o)
   );

   assign chg_rsel_o      = chg_q.rsel;
   assign chg_diode_off_o = chg_q.diode_off;
   assign chg_en_o        = chg_q.en;
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             por_n,
   input logic             sys_rst_n,
   input logic             keep,
   input logic             freeze,
   input logic             load,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] alarm,
   input logic             irq,
   input logic             pm
);
   // R7
   irq_one_clk_chk: assert property (@(posedge clk) disable iff (!por_n)
      irq |=> !irq);

   // R8
   alarm_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      irq |-> ($past(alarm) != '0));

   // R10
   pm_follows_chk: assert property (@(posedge clk) disable iff (!por_n)
      pm |-> irq);

   // R11
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      ($past(freeze) && !$past(load) && $past(sys_rst_n)) |-> $stable(count));

   // R12
   sys_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!sys_rst_n && !keep) |=> (count == '0 && alarm == '0));

   // R2
   single_step_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!$past(load) && $past(sys_rst_n)) |->
         (count == $past(count) || count == $past(count) + CNT_W'(1)));
endmodule

bind secs_rtc rtc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .sys_rst_n (sys_rst_n),
   .keep      (ctrl_q.keep),
   .freeze    (ctrl_q.freeze),
   .load      (time_load),
   .count     (count_q),
   .alarm     (alarm_q),
   .irq       (irq_o),
   .pm        (pm_wake_o)
);

// File: tb/secs_rtc_tb_top.sv
module secs_rtc_tb_top;
   localparam int PS = 4;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        sys_rst_n = 1'b1;
   logic        tick_en = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, pm_wake_o, chg_diode_off_o, chg_en_o;
   logic [1:0]  chg_rsel_o;

   int n_chk = 0;
   int n_fail = 0;
   int irq_cnt = 0;
   int pm_cnt = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   secs_rtc #(.PRESCALE(PS)) dut_i (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick_en(tick_en),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
      .pm_wake_o(pm_wake_o), .chg_rsel_o(chg_rsel_o),
      .chg_diode_off_o(chg_diode_off_o), .chg_en_o(chg_en_o)
   );

   always @(negedge clk) begin
      if (irq_o) irq_cnt++;
      if (pm_wake_o) pm_cnt++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_en = 1'b1;
         @(negedge clk); tick_en = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 irq", {31'b0, irq_o}, 0);
      chk("R1 pm", {31'b0, pm_wake_o}, 0);
      chk("R1 chg outs", {28'b0, chg_rsel_o, chg_diode_off_o, chg_en_o}, 0);
      rd(8'h40, d); chk("R1 ctrl", d, 0);
      rd(8'h44, d); chk("R1 count", d, 0);
      rd(8'h50, d); chk("R1 alarm", d, 0);
      rd(8'h5C, d); chk("R1 chg", d, 0);
   endtask

   task automatic t_prescale;
      logic [31:0] d;
      wr(8'h4C, 32'd0);
      tick(PS - 1);
      idle(5);                    // enable low: divider must not move
      rd(8'h44, d); chk("R2 before last tick", d, 0);
      tick(1);
      rd(8'h44, d); chk("R2 after PS ticks", d, 1);
      tick(2 * PS);
      rd(8'h44, d); chk("R2 after 3 seconds", d, 3);
   endtask

   task automatic t_load;
      logic [31:0] d;
      wr(8'h4C, 32'd7);
      tick(2);                    // partial phase, then reload
      wr(8'h4C, 32'h1234_0000);
      rd(8'h44, d); chk("R3 loaded", d, 32'h1234_0000);
      rd(8'h4C, d); chk("R3 set offset reads 0", d, 0);
      tick(PS - 1);
      rd(8'h44, d); chk("R3 phase restarted", d, 32'h1234_0000);
      tick(1);
      rd(8'h44, d); chk("R3 continues", d, 32'h1234_0001);
   endtask

   task automatic t_ctrl_mask;
      logic [31:0] d;
      wr(8'h40, 32'hFFFF_FFD7);   // all masks, bits 3 and 5 written 0
      rd(8'h40, d); chk("R5 masked set", d, 32'h0000_0017);
      wr(8'h40, 32'h0000_003F);   // no mask bits: no change
      rd(8'h40, d); chk("R5 no-mask ignored", d, 32'h0000_0017);
      wr(8'h40, 32'h0001_0000);   // clear bit 0 only
      rd(8'h40, d); chk("R5 single bit", d, 32'h0000_0016);
      wr(8'h40, 32'h003F_0000);
      rd(8'h40, d); chk("R5 cleared", d, 0);
   endtask

   task automatic t_charger;
      logic [31:0] d;
      wr(8'h5C, 32'h000F_000B);
      rd(8'h5C, d); chk("R6 readback", d, 32'h0000_000B);
      chk("R6 outputs", {28'b0, chg_rsel_o, chg_diode_off_o, chg_en_o}, 32'hB);
      wr(8'h5C, 32'h0001_0000);
      chk("R6 partial", {28'b0, chg_rsel_o, chg_diode_off_o, chg_en_o}, 32'hA);
      wr(8'h5C, 32'h000C_0004);
      rd(8'h5C, d); chk("R6 rsel field", d, 32'h0000_0006);
   endtask

   task automatic t_alarm;
      wr(8'h40, 32'h003F_0000);
      wr(8'h50, 32'd12);
      wr(8'h4C, 32'd10);
      wr(8'h40, 32'h0001_0001);
      idle(3); irq_cnt = 0; pm_cnt = 0;
      tick(PS); idle(3);
      chk("R7 no irq before match", irq_cnt, 0);
      tick(PS); idle(3);
      chk("R7 one pulse at match", irq_cnt, 1);
      chk("R10 pm off when route clear", pm_cnt, 0);
      tick(PS); idle(3);
      chk("R7 no repeat after match", irq_cnt, 1);
      wr(8'h40, 32'h0002_0002);
      wr(8'h50, 32'd21);
      wr(8'h4C, 32'd20);
      idle(3); irq_cnt = 0; pm_cnt = 0;
      tick(PS); idle(3);
      chk("R10 irq", irq_cnt, 1);
      chk("R10 pm pulse", pm_cnt, 1);
   endtask

   task automatic t_zero_wrap;
      logic [31:0] d;
      wr(8'h40, 32'h003F_0001);   // only alarm enable
      wr(8'h50, 32'd0);
      wr(8'h4C, 32'hFFFF_FFFF);
      idle(3); irq_cnt = 0;
      tick(PS); idle(3);
      rd(8'h44, d); chk("R4 wrap", d, 0);
      chk("R8 zero alarm silent", irq_cnt, 0);
   endtask

   task automatic t_overdue;
      wr(8'h40, 32'h003F_0005);   // enable + overdue
      wr(8'h50, 32'd0);
      wr(8'h4C, 32'd100);
      idle(3); irq_cnt = 0;
      wr(8'h50, 32'd50);
      idle(3);
      chk("R9 overdue fires", irq_cnt, 1);
      wr(8'h40, 32'h0004_0000);   // overdue off
      wr(8'h50, 32'd0);
      idle(3); irq_cnt = 0;
      wr(8'h50, 32'd40);
      idle(3);
      chk("R9 past alarm silent without overdue", irq_cnt, 0);
   endtask

   task automatic t_freeze_hold;
      logic [31:0] d;
      wr(8'h40, 32'h003F_0020);   // freeze only
      wr(8'h4C, 32'd200);
      tick(2 * PS);
      rd(8'h44, d); chk("R11 frozen", d, 200);
      wr(8'h4C, 32'd300);
      rd(8'h44, d); chk("R11 load while frozen", d, 300);
      wr(8'h40, 32'h0020_0000);
      tick(PS);
      rd(8'h44, d); chk("R11 resumes", d, 301);
      wr(8'h40, 32'h0008_0008);   // divider hold
      wr(8'h4C, 32'd400);
      tick(2 * PS);
      rd(8'h44, d); chk("R13 hold", d, 400);
      wr(8'h40, 32'h0008_0000);
      tick(PS);
      rd(8'h44, d); chk("R13 released", d, 401);
   endtask

   task automatic t_sysrst;
      logic [31:0] d;
      wr(8'h40, 32'h003F_0000);
      wr(8'h4C, 32'd500);
      wr(8'h50, 32'd600);
      @(negedge clk); sys_rst_n = 1'b0;
      @(negedge clk); sys_rst_n = 1'b1;
      rd(8'h44, d); chk("R12 count cleared", d, 0);
      rd(8'h50, d); chk("R12 alarm cleared", d, 0);
      rd(8'h5C, d); chk("R12 charger kept", d, 32'h0000_0006);
      wr(8'h40, 32'h0010_0010);   // keep
      wr(8'h4C, 32'd700);
      wr(8'h50, 32'd800);
      @(negedge clk); sys_rst_n = 1'b0;
      @(negedge clk); sys_rst_n = 1'b1;
      rd(8'h44, d); chk("R12 count kept", d, 700);
      rd(8'h50, d); chk("R12 alarm kept", d, 800);
      rd(8'h40, d); chk("R12 ctrl kept", d, 32'h0000_0010);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         report();
      end
   end

   initial begin
      idle(4);
      por_n = 1'b1;
      idle(2);
      t_reset();
      t_prescale();
      t_load();
      t_ctrl_mask();
      t_charger();
      t_alarm();
      t_zero_wrap();
      t_overdue();
      t_freeze_hold();
      t_sysrst();
      done = 1;
      report();
   end
endmodule